// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block sits between a small CPU core and the clock tree of a microcontroller. It decides which clock domains run in each low-power state. Software writes a 4-bit control register holding a sleep-enable bit and a 3-bit mode code. A single-cycle sleep strobe from the core then moves the block into the chosen state. There it drives the CPU, flash, I/O, ADC and PLL clock enables and the main oscillator enable for that state.

While asleep, the block watches five interrupt request lines and a reset request. All of them are first synchronised to the always-on clock. When a source that the current mode accepts becomes active, the block starts the wake sequence:

- It re-enables the oscillator.
- It waits a start-up delay. The delay is only non-zero in modes that stopped the oscillator.
- It holds the CPU clock off for four further cycles while the other domains run.
- It then releases the core.

A reset request during any non-active state returns the block to the active state at once. The block then pulses a flag that tells the core to restart from the reset vector.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: A sleep strobe while the sleep-enable bit (cfg_q[0]) is 0 is ignored. The block stays in the active state and every clock enable stays 1.
- R2: The control register resets to 0 and is loaded from cfg_wdata when cfg_we is 1. Bit 0 is sleep enable and bits 3:1 are the mode code. cfg_q shows its value.
- R3: The mode codes are 000 Idle, 001 ADC noise reduction, 010 Power-down, 011 Power-save and 110 Standby. A strobe with code 100, 101 or 111 is ignored even with sleep enable set.
- R4: pm_state encodes the state as 0 active, 1 asleep, 2 oscillator start-up and 3 CPU halt. In the active state all six enables are 1. A valid strobe makes pm_state 1 after the next clock edge.
- R5: In Idle, only the CPU and flash enables are 0. Idle wakes on any of the five interrupt lines: ext_lvl_irq, ext_edge_irq, io_irq, adc_irq and wdt_irq.
- R6: In ADC noise reduction, only the ADC clock and the oscillator are enabled. It wakes on adc_irq, wdt_irq, ext_lvl_irq or ext_edge_irq, and ignores io_irq.
- R7: In Power-down, all five domain enables and osc_en are 0. It wakes only on ext_lvl_irq or wdt_irq. Edge-detected external interrupts, io_irq and adc_irq are ignored.
- R8: Power-save gates the same clocks as Power-down. It also accepts io_irq as a wake source.
- R9: In Standby, osc_en stays 1 while all five domain enables are 0. It wakes only on ext_lvl_irq or wdt_irq.
- R10: Suppose an accepted interrupt becomes 1 just before clock edge 1. Then cpu_clk_en becomes 1 at edge 7+D, where D is START_CYC for Power-down and Power-save and 0 for the other modes. During the last four of those cycles, pm_state is 3 and every enable except cpu_clk_en is 1.
- R11: Suppose rst_req becomes 1 in a non-active state, just before edge 1. Then at edge 3, pm_state returns to 0 and rst_vec is 1 for exactly one cycle. In the active state, rst_req has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control register write data: bit 0 sleep enable, bits 3:1 mode |
| cfg_q | output | 4 | Control register contents |
| sleep_req | input | 1 | Sleep strobe from the CPU |
| ext_lvl_irq | input | 1 | Enabled level-detected external interrupt request |
| ext_edge_irq | input | 1 | Enabled edge-detected external interrupt request |
| io_irq | input | 1 | Enabled I/O peripheral interrupt request (timer, serial) |
| adc_irq | input | 1 | Enabled ADC conversion-complete interrupt |
| wdt_irq | input | 1 | Enabled watchdog interrupt |
| rst_req | input | 1 | Reset request that wakes the block |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| pll_clk_en | output | 1 | PLL clock enable |
| osc_en | output | 1 | Main oscillator enable |
| rst_vec | output | 1 | One-cycle flag: restart from the reset vector |
| pm_state | output | 2 | Current state code |

## Verification
The hardest case to reach from the ports is the proof that a source is rejected in a deep mode. The rejected source has to stay asserted for longer than the full start-up-plus-halt window without the block leaving sleep. Afterwards the block still has to be brought back to the active state for the next trial.

The bench sweeps every valid mode against every interrupt line. For each rejected source it holds the line for that window and checks that the state and all enables are unchanged. It then drops the line, lets the synchronisers drain, and uses a reset request to wake the block, which also measures the reset-vector pulse. Each accepted source is timed edge by edge against 7 plus the mode's start-up count.

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl #(
  parameter int START_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  output logic [3:0] cfg_q,
  input  logic       sleep_req,
  input  logic       ext_lvl_irq,
  input  logic       ext_edge_irq,
  input  logic       io_irq,
  input  logic       adc_irq,
  input  logic       wdt_irq,
  input  logic       rst_req,
  output logic       cpu_clk_en,
  output logic       flash_clk_en,
  output logic       io_clk_en,
  output logic       adc_clk_en,
  output logic       pll_clk_en,
  output logic       osc_en,
  output logic       rst_vec,
  output logic [1:0] pm_state
);
  localparam int CW = (START_CYC > 3) ? $clog2(START_CYC + 1) : 2;
  localparam logic [2:0] M_IDLE = 3'b000, M_ADCNR = 3'b001, M_PDOWN = 3'b010,
                         M_PSAVE = 3'b011, M_STBY = 3'b110;
  localparam logic [1:0] S_ACT = 2'd0, S_SLP = 2'd1, S_START = 2'd2, S_HALT = 2'd3;

  logic [5:0]    sync1, sync2;
  logic [2:0]    cur_mode;
  logic [CW-1:0] cnt;
  logic [1:0]    st;
  logic [4:0]    wmask;
  logic [5:0]    slp_en;
  logic          mode_ok, osc_off, wake;

  assign mode_ok = (cfg_q[3:1] == M_IDLE) || (cfg_q[3:1] == M_ADCNR) ||
                   (cfg_q[3:1] == M_PDOWN) || (cfg_q[3:1] == M_PSAVE) ||
                   (cfg_q[3:1] == M_STBY);
  assign osc_off = (cur_mode == M_PDOWN) || (cur_mode == M_PSAVE);

  // wake mask bits: {wdt, adc, io, edge, lvl}
  assign wmask[0] = 1'b1;
  assign wmask[1] = (cur_mode == M_IDLE) || (cur_mode == M_ADCNR);
  assign wmask[2] = (cur_mode == M_IDLE) || (cur_mode == M_PSAVE);
  assign wmask[3] = (cur_mode == M_IDLE) || (cur_mode == M_ADCNR);
  assign wmask[4] = 1'b1;
  assign wake = |(sync2[4:0] & wmask);

  // sleep enables: {io, adc, pll, flash, cpu, osc}
  always_comb begin
    case (cur_mode)
      M_IDLE:  slp_en = 6'b111001;
      M_ADCNR: slp_en = 6'b010001;
      M_STBY:  slp_en = 6'b000001;
      default: slp_en = 6'b000000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {rst_req, wdt_irq, adc_irq, io_irq, ext_edge_irq, ext_lvl_irq};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_ACT;
      cur_mode <= M_IDLE;
      cnt      <= '0;
      rst_vec  <= 1'b0;
    end else begin
      rst_vec <= 1'b0;
      if (st != S_ACT && sync2[5]) begin
        st      <= S_ACT;
        rst_vec <= 1'b1;
      end else begin
        case (st)
          S_ACT:
            if (sleep_req && cfg_q[0] && mode_ok) begin
              st       <= S_SLP;
              cur_mode <= cfg_q[3:1];
            end
          S_SLP:
            if (wake) begin
              if (osc_off && START_CYC > 0) begin
                st  <= S_START;
                cnt <= CW'(START_CYC - 1);
              end else begin
                st  <= S_HALT;
                cnt <= CW'(3);
              end
            end
          S_START:
            if (cnt == '0) begin
              st  <= S_HALT;
              cnt <= CW'(3);
            end else cnt <= cnt - 1'b1;
          default:
            if (cnt == '0) st <= S_ACT;
            else           cnt <= cnt - 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_ACT:   {io_clk_en, adc_clk_en, pll_clk_en, flash_clk_en, cpu_clk_en, osc_en} = 6'b111111;
      S_SLP:   {io_clk_en, adc_clk_en, pll_clk_en, flash_clk_en, cpu_clk_en, osc_en} = slp_en;
      S_START: {io_clk_en, adc_clk_en, pll_clk_en, flash_clk_en, cpu_clk_en, osc_en} = slp_en | 6'b000001;
      default: {io_clk_en, adc_clk_en, pll_clk_en, flash_clk_en, cpu_clk_en, osc_en} = 6'b111101;
    endcase
  end

  assign pm_state = st;
endmodule

module sleep_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [3:0] cfg_q,
  input logic [2:0] cur_mode,
  input logic [1:0] pm_state,
  input logic       cpu_clk_en,
  input logic       flash_clk_en,
  input logic       io_clk_en,
  input logic       adc_clk_en,
  input logic       pll_clk_en,
  input logic       osc_en,
  input logic       rst_vec
);
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_req && !cfg_q[0]) |=> (pm_state == 2'd0)); // R1
  AST_RESERVED_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_req && cfg_q[3] && cfg_q[2:1] != 2'b10) |=> (pm_state == 2'd0)); // R3
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd1 && cur_mode == 3'b000) |->
    (io_clk_en && adc_clk_en && pll_clk_en && osc_en && !flash_clk_en && !cpu_clk_en)); // R5
  AST_STANDBY_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd1 && cur_mode == 3'b110) |->
    (osc_en && !io_clk_en && !adc_clk_en && !pll_clk_en && !flash_clk_en && !cpu_clk_en)); // R9
  AST_PDOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd1 && cur_mode == 3'b010) |->
    !(osc_en || io_clk_en || adc_clk_en || pll_clk_en || flash_clk_en || cpu_clk_en)); // R7
  AST_HALT_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && !rst_vec) |->
    ($past(pm_state, 1) == 2'd3 && $past(pm_state, 4) == 2'd3)); // R10
  AST_RSTVEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_vec |=> !rst_vec); // R11
  AST_RSTVEC_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_vec |-> (pm_state == 2'd0 && $past(pm_state) != 2'd0)); // R11
endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cfg_q(cfg_q), .cur_mode(cur_mode),
  .pm_state(pm_state), .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en),
  .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en), .pll_clk_en(pll_clk_en),
  .osc_en(osc_en), .rst_vec(rst_vec)
);

// File: tb/sim_sleep_clk_ctrl.sv
module sim_sleep_clk_ctrl;
  localparam int SC = 16;

  logic clk = 0, rst_n = 0, cfg_we = 0, sleep_req = 0, rst_req = 0;
  logic [3:0] cfg_wdata = 0;
  logic [4:0] src = 0;
  logic [3:0] cfg_q;
  logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, pll_clk_en, osc_en, rst_vec;
  logic [1:0] pm_state;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sleep_clk_ctrl #(.START_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .sleep_req(sleep_req), .ext_lvl_irq(src[0]), .ext_edge_irq(src[1]), .io_irq(src[2]),
    .adc_irq(src[3]), .wdt_irq(src[4]), .rst_req(rst_req),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
    .adc_clk_en(adc_clk_en), .pll_clk_en(pll_clk_en), .osc_en(osc_en),
    .rst_vec(rst_vec), .pm_state(pm_state)
  );

  function automatic logic [5:0] clks();
    return {io_clk_en, adc_clk_en, pll_clk_en, flash_clk_en, cpu_clk_en, osc_en};
  endfunction

  // expected sleep enables {io, adc, pll, flash, cpu, osc}
  function automatic logic [5:0] exp_clks(input logic [2:0] m);
    case (m)
      3'd0: return 6'b111001;   // R5
      3'd1: return 6'b010001;   // R6
      3'd6: return 6'b000001;   // R9
      default: return 6'b000000; // R7 R8
    endcase
  endfunction

  function automatic bit accepts(input logic [2:0] m, input int s);
    case (s)
      0, 4: return 1'b1;
      1, 3: return (m == 3'd0 || m == 3'd1);
      2:    return (m == 3'd0 || m == 3'd3);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_wdata = v; cfg_we = 1;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic strobe();
    sleep_req = 1;
    cyc(1);
    sleep_req = 0;
  endtask

  task automatic reset_wake(input string req);
    rst_req = 1;
    for (int i = 1; i <= 4; i++) begin
      cyc(1);
      if (i == 2) chk(pm_state == 2'd1, req, pm_state, 1);
      if (i == 3) begin
        chk(pm_state == 2'd0, req, pm_state, 0);
        chk(rst_vec == 1'b1, req, rst_vec, 1);
      end
      if (i == 4) chk(rst_vec == 1'b0, req, rst_vec, 0);
    end
    rst_req = 0;
    cyc(3);
  endtask

  initial begin
    int first, d;
    logic [2:0] m;
    logic [2:0] modes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6};
    cyc(2);
    chk(cfg_q == 4'h0, "R2 reset cfg", cfg_q, 0);
    chk(pm_state == 2'd0, "R4 reset state", pm_state, 0);
    chk(clks() == 6'b111111, "R4 reset clocks", clks(), 63);
    rst_n = 1;
    cyc(2);

    write_cfg(4'b0100);
    chk(cfg_q == 4'b0100, "R2 write", cfg_q, 4);
    strobe();
    cyc(1);
    chk(pm_state == 2'd0, "R1 se=0 strobe", pm_state, 0);
    chk(clks() == 6'b111111, "R1 se=0 clocks", clks(), 63);

    for (int c = 4; c < 8; c++) begin
      if (c == 6) continue;
      write_cfg({c[2:0], 1'b1});
      strobe();
      cyc(1);
      chk(pm_state == 2'd0, "R3 reserved", pm_state, 0);
      chk(clks() == 6'b111111, "R3 reserved clocks", clks(), 63);
    end

    rst_req = 1; cyc(4);
    chk(pm_state == 2'd0 && rst_vec == 0, "R11 active rst_req", rst_vec, 0);
    rst_req = 0; cyc(3);

    for (int mi = 0; mi < 5; mi++) begin
      m = modes[mi];
      d = (m == 3'd2 || m == 3'd3) ? SC : 0;
      for (int s = 0; s < 5; s++) begin
        write_cfg({m, 1'b1});
        chk(cfg_q == {m, 1'b1}, "R2 mode write", cfg_q, {m, 1'b1});
        strobe();
        chk(pm_state == 2'd1, "R4 enter", pm_state, 1);
        chk(clks() == exp_clks(m), "R5 R6 R7 R8 R9 sleep clocks", clks(), exp_clks(m));
        src[s] = 1;
        if (accepts(m, s)) begin
          first = 0;
          for (int i = 1; i <= 12 + d; i++) begin
            cyc(1);
            if (cpu_clk_en && first == 0) first = i;
            if (i == 5 + d) begin
              chk(pm_state == 2'd3, "R10 halt state", pm_state, 3);
              chk(clks() == 6'b111101, "R10 halt clocks", clks(), 61);
            end
            if (i == 3 && d > 0) chk(osc_en == 1'b1, "R10 osc start", osc_en, 1);
          end
          chk(first == 7 + d, "R10 R5 R6 R8 wake time", first, 7 + d);
          chk(rst_vec == 1'b0, "R10 no rst_vec", rst_vec, 0);
          src[s] = 0;
          cyc(3);
        end else begin
          cyc(12 + d);
          chk(pm_state == 2'd1, "R6 R7 R9 ignored source", pm_state, 1);
          chk(clks() == exp_clks(m), "R7 R8 R9 clocks held", clks(), exp_clks(m));
          src[s] = 0;
          cyc(3);
          reset_wake("R11 reset wake");
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule